// File: doc/BRIEF.md
# Shared Command Register with Read-Side Lock

This block is the command register front end that several host processors share over one register bus. It holds a single lock flag that works as a test-and-set semaphore. A host claims the flag by reading one of four alias addresses and releases it by reading an unlock alias. The read returns the value the flag had before that read, so a host that sees 0 knows it now holds the lock. While the command engine reports busy, no read changes the flag. Writes never change it.

A write to the command address pushes the data word into a four-entry command FIFO, whatever the lock or busy state. The command engine drains the FIFO through a valid/ready handshake. When the FIFO is full, a write to the command address is dropped and a sticky overflow flag is set. The flag is read at its own address.

Top module: `cmd_lock_regs`

## Requirements
- R1: After reset the lock flag is 0, the FIFO is empty (`cmd_valid` low) and the overflow flag is 0.
- R2: A read (`bus_rd` high) of addresses 0..3 returns `busy_in` at bit 31 and the lock flag as it was before this read at bit 30, with all other bits 0. A read of address 4 returns the overflow flag at bit 0, with all other bits 0. Any other read address, and any cycle without `bus_rd`, returns 0.
- R3: When the flag is 0 and `busy_in` is 0, a read of any of addresses 0 (command), 1 (command-unlock), 2 (extension) or 3 (extension-unlock) sets the flag to 1 at the next edge.
- R4: When the flag is 1 and `busy_in` is 0, a read of address 1 or 3 clears the flag to 0.
- R5: When the flag is 1, a read of address 0 or 2 leaves it at 1.
- R6: While `busy_in` is 1, no read changes the flag.
- R7: A write to any address never changes the lock flag.
- R8: A write to address 0 appends `bus_wdata` to the FIFO regardless of lock and busy state. `cmd_valid` is high while the FIFO holds a word, and `cmd_data` shows the oldest word. The word is removed on an edge where `cmd_valid` and `cmd_ready` are both high. Writes to other addresses push nothing.
- R9: A write to address 0 while the FIFO holds 4 words at the start of the cycle is dropped, even if a pop happens in the same cycle. The write sets the overflow flag, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| busy_in | input | 1 | Command engine busy, freezes the lock |
| cmd_valid | output | 1 | FIFO head word is valid |
| cmd_data | output | 32 | FIFO head word |
| cmd_ready | input | 1 | Command engine accepts the head word |

## Verification
The hardest case to reach is a set of coinciding events: a command write arriving while the FIFO is full and the engine pops in the same cycle, together with a read while busy that would otherwise move the lock. The stimulus holds `cmd_ready` low to fill the FIFO past its depth. It then raises ready on the same cycle as a further write, and toggles `busy_in` around unlock reads while the flag is 1. A long random phase then mixes reads, writes, busy and ready on every cycle against the bench's queue model.

// File: rtl/cmd_lock_regs.sv
module cmd_lock_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy_in,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ready
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD_UNL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EXT     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EXT_UNL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_OVF     = ADDR_W'(4);
  localparam logic [PTR_W-1:0]  LAST_PTR  = PTR_W'(DEPTH - 1);

  logic lock_q, lock_d, ovf_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  wire is_alias = (bus_addr == A_CMD) || (bus_addr == A_CMD_UNL) ||
                  (bus_addr == A_EXT) || (bus_addr == A_EXT_UNL);
  wire is_unl   = (bus_addr == A_CMD_UNL) || (bus_addr == A_EXT_UNL);
  wire lock_rd  = bus_rd && is_alias && !busy_in;
  wire full     = (count == CNT_W'(DEPTH));
  wire push_req = bus_wr && (bus_addr == A_CMD);
  wire push     = push_req && !full;
  wire pop      = cmd_valid && cmd_ready;

  assign cmd_valid = (count != '0);
  assign cmd_data  = mem[rd_ptr];

  always_comb begin
    lock_d = lock_q;
    if (lock_rd) begin
      if (!lock_q)     lock_d = 1'b1;
      else if (is_unl) lock_d = 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (is_alias) begin
        bus_rdata[DATA_W-1] = busy_in;
        bus_rdata[DATA_W-2] = lock_q;
      end else if (bus_addr == A_OVF) begin
        bus_rdata[0] = ovf_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      if (push_req && full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_lock_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_alias && !busy_in && !lock_q) |=> lock_q);
  assert_lock_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_unl && !busy_in && lock_q) |=> !lock_q);
  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_CMD || bus_addr == A_EXT) && lock_q) |=> lock_q);
  assert_busy_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> $stable(lock_q));
  assert_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd) |=> $stable(lock_q));
  assert_push_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !full && !pop) |=> (count == $past(count) + 1'b1));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q || (push_req && full)) |=> ovf_q);
endmodule

// File: tb/tb_cmd_lock_regs.sv
module tb_cmd_lock_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, busy_in = 1'b0, cmd_ready = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, cmd_data;
  logic cmd_valid;

  always #2.5 clk = ~clk;

  cmd_lock_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_in(busy_in), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  bit m_lock = 0, m_ovf = 0;
  logic [31:0] m_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit rd, input bit wr, input logic [2:0] a,
                     input logic [31:0] wd, input bit busy, input bit rdy,
                     input string tag);
    logic [31:0] exp_rd;
    bit full;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    busy_in = busy; cmd_ready = rdy;
    #1;
    exp_rd = '0;
    if (rd && a <= 3) exp_rd = {busy, m_lock, 30'b0};
    else if (rd && a == 4) exp_rd = {31'b0, m_ovf};
    chk(tag, bus_rdata, exp_rd);
    chk("R8 valid", {31'b0, cmd_valid}, {31'b0, m_q.size() > 0});
    if (m_q.size() > 0) chk("R8 data", cmd_data, m_q[0]);
    full = (m_q.size() == 4);
    if (m_q.size() > 0 && rdy) void'(m_q.pop_front());
    if (wr && a == 0) begin
      if (full) m_ovf = 1;
      else m_q.push_back(wd);
    end
    if (rd && a <= 3 && !busy) begin
      if (!m_lock) m_lock = 1;
      else if (a == 1 || a == 3) m_lock = 0;
    end
  endtask

  initial begin
    #(5 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 valid", {31'b0, cmd_valid}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    cyc(1, 0, 4, 0, 0, 0, "R1 ovf");
    cyc(1, 0, 0, 0, 0, 0, "R3 take via cmd");
    cyc(1, 0, 0, 0, 0, 0, "R5 hold cmd");
    cyc(1, 0, 2, 0, 0, 0, "R5 hold ext");
    cyc(1, 0, 1, 0, 0, 0, "R4 unlock cmd");
    cyc(1, 0, 2, 0, 0, 0, "R3 take via ext");
    cyc(1, 0, 3, 0, 0, 0, "R4 unlock ext");
    cyc(1, 0, 3, 0, 0, 0, "R3 take via ext-unl");
    cyc(1, 0, 1, 0, 1, 0, "R6 busy unlock");
    cyc(1, 0, 0, 0, 0, 0, "R6 still locked");
    cyc(1, 0, 1, 0, 0, 0, "R4 unlock");
    cyc(1, 0, 0, 0, 1, 0, "R6 busy take");
    cyc(1, 0, 2, 0, 0, 0, "R6 still free");
    cyc(0, 1, 1, 32'h1, 0, 0, "R7 write");
    cyc(1, 0, 0, 0, 0, 0, "R7 lock kept");
    cyc(0, 1, 2, 32'h99, 0, 0, "R8 no push ext");
    for (int i = 0; i < 6; i++)
      cyc(0, 1, 0, 32'hA000 + i, i[0], 0, "R8 push");
    cyc(1, 0, 4, 0, 0, 0, "R9 ovf set");
    cyc(0, 1, 0, 32'hBEEF, 0, 1, "R9 full pop drop");
    cyc(0, 0, 0, 0, 0, 1, "R8 drain");
    cyc(1, 0, 4, 0, 0, 1, "R9 sticky");
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 1), $urandom_range(0, 1), 3'($urandom_range(0, 5)),
          $urandom, $urandom_range(0, 3) == 0, $urandom_range(0, 1), "R2 random");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule